// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block caches recent page-to-frame translations in a small fully associative table. Every entry holds a virtual page number, an address-space identifier, a frame number, a write-permission bit and a valid bit. A lookup is compared against all entries at once. It matches only when the page number and the identifier both agree, so translations from several processes live side by side and a context switch needs no flush. A matching entry returns its frame at once. A write to a read-only page returns a protection fault instead of a hit. No match means a miss, and the requester must then fetch the translation from the page table and install it through the fill port.

Lookups enter on a valid/ready channel and leave one cycle later on a registered response channel with its own valid/ready pair. The response register holds its value until the consumer takes it. The lookup side is ready whenever that register is empty or is being drained in the same cycle, so back-pressure on the response stalls new lookups. Fills use a valid/ready pair. The fill side refuses entries in any cycle in which an invalidate command is present. The invalidate pins are plain control inputs. One clears the whole table. The other clears only the entries of a given identifier.

Top module: `asid_tlb`

## Requirements
- R1: After reset no entry is valid, `rsp_valid` is 0, `lk_ready` and `fill_ready` are 1, and the replacement pointer is at entry 0.
- R2: A lookup whose page number and ASID both equal those of a valid entry returns `rsp_hit`=1 with that entry's frame, provided it is not a write to a read-only entry.
- R3: A lookup with no valid entry matching on both page number and ASID returns `rsp_hit`=0, `rsp_fault`=0 and `rsp_frame`=0. This includes a lookup with the same page number under a different ASID.
- R4: The permission bit is 1 for read-write and 0 for read-only. A write lookup (`lk_write`=1) that matches a read-only entry returns `rsp_fault`=1, `rsp_hit`=0 and frame 0. A read lookup of that entry is a hit.
- R5: A lookup accepted at a clock edge (`lk_valid` and `lk_ready` both 1) presents its response from that edge onwards. The response holds unchanged while `rsp_ready` is 0. `lk_ready` equals NOT `rsp_valid` OR `rsp_ready`.
- R6: A lookup accepted in the same cycle as a fill or an invalidate sees the table contents from before that cycle.
- R7: Filling a page/ASID pair that is already valid overwrites that entry (frame and permission), so a pair never occupies two entries.
- R8: A fill of a new pair goes to the lowest-numbered invalid entry when one exists, and the replacement pointer does not move.
- R9: A fill of a new pair into a full table replaces the entry at the round-robin pointer, which then advances by one and wraps from the last entry to 0.
- R10: Asserting `inv_all` for one cycle clears every entry.
- R11: Asserting `inv_asid_en` clears exactly the entries whose ASID equals `inv_asid` and leaves all others intact.
- R12: `fill_ready` is 0 while `inv_all` or `inv_asid_en` is 1, and a fill offered then leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_vpn | input | 22 | Lookup virtual page number |
| lk_asid | input | 8 | Lookup address-space identifier |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Translation found and access allowed |
| rsp_fault | output | 1 | Write to a read-only page |
| rsp_frame | output | 22 | Frame number on a hit, otherwise 0 |
| fill_valid | input | 1 | Fill request present |
| fill_ready | output | 1 | Fill can be accepted |
| fill_vpn | input | 22 | Page number to install |
| fill_asid | input | 8 | ASID to install |
| fill_frame | input | 22 | Frame number to install |
| fill_writable | input | 1 | 1 = read-write page, 0 = read-only |
| inv_all | input | 1 | Clear all entries |
| inv_asid_en | input | 1 | Clear entries of one ASID |
| inv_asid | input | 8 | ASID to clear |

## Verification
Lookups are tried against an empty table, against entries that differ only in ASID or only in page number, and against read-only and read-write pages with both access types. These patterns separate a full-key match from a partial one and a fault from a hit. The table is then filled past its capacity with distinct pairs and probed. This shows whether invalid slots are taken in index order and whether the pointer walks and wraps correctly. Further cases refill an existing pair, hold the response under back-pressure, issue lookups in the same cycle as fills and invalidates, and offer fills during an invalidate. These show whether duplicates can form and whether a lookup sees the table from before the update.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned DEF_ENTRIES = 16;
  localparam int unsigned DEF_ASID_W  = 8;
  localparam int unsigned DEF_VPN_W   = 22;
  localparam int unsigned DEF_FRAME_W = 22;

  typedef enum logic [1:0] {
    OUT_MISS  = 2'd0,
    OUT_HIT   = 2'd1,
    OUT_FAULT = 2'd2
  } tlb_outcome_e;
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter int unsigned ENTRIES = tlb_pkg::DEF_ENTRIES,
  parameter int unsigned ASID_W  = tlb_pkg::DEF_ASID_W,
  parameter int unsigned VPN_W   = tlb_pkg::DEF_VPN_W,
  parameter int unsigned FRAME_W = tlb_pkg::DEF_FRAME_W,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [ASID_W-1:0]  lk_asid,
  output logic [ENTRIES-1:0] lk_match,
  output logic [FRAME_W-1:0] lk_frame,
  output logic               lk_writable,
  input  logic [VPN_W-1:0]   fl_vpn,
  input  logic [ASID_W-1:0]  fl_asid,
  output logic [ENTRIES-1:0] fl_match,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic               wr_writable,
  input  logic               inv_all,
  input  logic               inv_asid_en,
  input  logic [ASID_W-1:0]  inv_asid,
  output logic [ENTRIES-1:0] valid_vec
);
  logic [VPN_W-1:0]   tag_vpn  [ENTRIES];
  logic [ASID_W-1:0]  tag_asid [ENTRIES];
  logic [FRAME_W-1:0] data_frm [ENTRIES];
  logic [ENTRIES-1:0] data_wr;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_vec[g] <= 1'b0;
        tag_vpn[g]   <= '0;
        tag_asid[g]  <= '0;
        data_frm[g]  <= '0;
        data_wr[g]   <= 1'b0;
      end else if (inv_all) begin
        valid_vec[g] <= 1'b0;
      end else if (inv_asid_en) begin
        if (tag_asid[g] == inv_asid) valid_vec[g] <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        valid_vec[g] <= 1'b1;
        tag_vpn[g]   <= fl_vpn;
        tag_asid[g]  <= fl_asid;
        data_frm[g]  <= wr_frame;
        data_wr[g]   <= wr_writable;
      end
    end

    assign lk_match[g] = valid_vec[g] && (tag_vpn[g] == lk_vpn) && (tag_asid[g] == lk_asid);
    assign fl_match[g] = valid_vec[g] && (tag_vpn[g] == fl_vpn) && (tag_asid[g] == fl_asid);
  end

  always_comb begin
    lk_frame    = '0;
    lk_writable = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        lk_frame    = lk_frame | data_frm[i];
        lk_writable = lk_writable | data_wr[i];
      end
    end
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match)); // R7

  AST_INV_ALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_vec == '0)); // R10
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int unsigned ENTRIES = tlb_pkg::DEF_ENTRIES,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] fl_match,
  input  logic               fill_fire,
  output logic [IDX_W-1:0]   victim_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] match_idx;
  logic [IDX_W-1:0] free_idx;
  logic             any_match;
  logic             any_free;

  always_comb begin
    match_idx = '0;
    any_match = 1'b0;
    free_idx  = '0;
    any_free  = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (fl_match[i]) begin
        match_idx = IDX_W'(i);
        any_match = 1'b1;
      end
      if (!valid_vec[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
    if (any_match)     victim_idx = match_idx;
    else if (any_free) victim_idx = free_idx;
    else               victim_idx = rr_ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (fill_fire && !any_match && !any_free) begin
      rr_ptr <= (rr_ptr == LAST_IDX) ? '0 : rr_ptr + 1'b1;
    end
  end

  AST_RR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_ptr == $past(rr_ptr)) ||
    (rr_ptr == (($past(rr_ptr) == LAST_IDX) ? '0 : $past(rr_ptr) + 1'b1))); // R9

  AST_FREE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_fire && any_free) |=> $stable(rr_ptr)); // R8
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int unsigned ENTRIES = tlb_pkg::DEF_ENTRIES,
  parameter int unsigned ASID_W  = tlb_pkg::DEF_ASID_W,
  parameter int unsigned VPN_W   = tlb_pkg::DEF_VPN_W,
  parameter int unsigned FRAME_W = tlb_pkg::DEF_FRAME_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  output logic               lk_ready,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [ASID_W-1:0]  lk_asid,
  input  logic               lk_write,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_hit,
  output logic               rsp_fault,
  output logic [FRAME_W-1:0] rsp_frame,
  input  logic               fill_valid,
  output logic               fill_ready,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [ASID_W-1:0]  fill_asid,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic               fill_writable,
  input  logic               inv_all,
  input  logic               inv_asid_en,
  input  logic [ASID_W-1:0]  inv_asid
);
  import tlb_pkg::*;
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] lk_match, fl_match, valid_vec;
  logic [FRAME_W-1:0] lk_frame;
  logic               lk_writable;
  logic [IDX_W-1:0]   victim_idx;
  logic               lk_fire, fill_fire;
  tlb_outcome_e       outcome_d, outcome_q;
  logic [FRAME_W-1:0] frame_q;

  assign lk_ready   = !rsp_valid || rsp_ready;
  assign lk_fire    = lk_valid && lk_ready;
  assign fill_ready = !(inv_all || inv_asid_en);
  assign fill_fire  = fill_valid && fill_ready;

  tlb_entry_array #(
    .ENTRIES(ENTRIES), .ASID_W(ASID_W), .VPN_W(VPN_W), .FRAME_W(FRAME_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n),
    .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_match(lk_match), .lk_frame(lk_frame), .lk_writable(lk_writable),
    .fl_vpn(fill_vpn), .fl_asid(fill_asid), .fl_match(fl_match),
    .wr_en(fill_fire), .wr_idx(victim_idx),
    .wr_frame(fill_frame), .wr_writable(fill_writable),
    .inv_all(inv_all), .inv_asid_en(inv_asid_en), .inv_asid(inv_asid),
    .valid_vec(valid_vec)
  );

  tlb_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n),
    .valid_vec(valid_vec), .fl_match(fl_match),
    .fill_fire(fill_fire), .victim_idx(victim_idx)
  );

  always_comb begin
    if (lk_match == '0)              outcome_d = OUT_MISS;
    else if (lk_write && !lk_writable) outcome_d = OUT_FAULT;
    else                             outcome_d = OUT_HIT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      outcome_q <= OUT_MISS;
      frame_q   <= '0;
    end else if (lk_fire) begin
      rsp_valid <= 1'b1;
      outcome_q <= outcome_d;
      frame_q   <= (outcome_d == OUT_HIT) ? lk_frame : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign rsp_hit   = rsp_valid && (outcome_q == OUT_HIT);
  assign rsp_fault = rsp_valid && (outcome_q == OUT_FAULT);
  assign rsp_frame = rsp_valid ? frame_q : '0;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_frame) &&
                                   $stable(rsp_hit) && $stable(rsp_fault))); // R5

  AST_MISS_FRAME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_frame == '0)); // R3

  AST_FAULT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_fire && lk_match != '0 && !lk_write) |=> !rsp_fault); // R4
endmodule

// File: tb/asid_tlb_tb.sv
module asid_tlb_tb_top;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 0, lk_write = 0, rsp_ready = 1;
  logic [21:0] lk_vpn = '0;
  logic [7:0]  lk_asid = '0;
  logic fill_valid = 0, fill_writable = 0;
  logic [21:0] fill_vpn = '0, fill_frame = '0;
  logic [7:0]  fill_asid = '0;
  logic inv_all = 0, inv_asid_en = 0;
  logic [7:0] inv_asid = '0;
  logic lk_ready, rsp_valid, rsp_hit, rsp_fault, fill_ready;
  logic [21:0] rsp_frame;

  always #5 clk = ~clk;

  asid_tlb dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_write(lk_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_frame(rsp_frame),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn),
    .fill_asid(fill_asid), .fill_frame(fill_frame), .fill_writable(fill_writable),
    .inv_all(inv_all), .inv_asid_en(inv_asid_en), .inv_asid(inv_asid)
  );

  int checks = 0, failures = 0;
  string cur_tag = "R1";

  // behavioural reference
  bit          m_v   [N];
  int          m_vpn [N];
  int          m_asid[N];
  int          m_frm [N];
  bit          m_wr  [N];
  int          m_rr = 0;
  bit          e_valid = 0, e_hit = 0, e_fault = 0;
  int          e_frame = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
      m_rr = 0; e_valid = 0; e_hit = 0; e_fault = 0; e_frame = 0;
    end else begin
      bit acc;
      acc = lk_valid && (!e_valid || rsp_ready);
      if (acc) begin
        int hit_i;
        hit_i = -1;
        for (int i = 0; i < N; i++)
          if (m_v[i] && m_vpn[i] == int'(lk_vpn) && m_asid[i] == int'(lk_asid)) hit_i = i;
        e_valid = 1;
        e_hit = 0; e_fault = 0; e_frame = 0;
        if (hit_i >= 0) begin
          if (lk_write && !m_wr[hit_i]) e_fault = 1;
          else begin e_hit = 1; e_frame = m_frm[hit_i]; end
        end
      end else if (rsp_ready) e_valid = 0;

      if (inv_all) begin
        for (int i = 0; i < N; i++) m_v[i] = 0;
      end else if (inv_asid_en) begin
        for (int i = 0; i < N; i++) if (m_asid[i] == int'(inv_asid)) m_v[i] = 0;
      end else if (fill_valid) begin
        int slot;
        slot = -1;
        for (int i = 0; i < N; i++)
          if (m_v[i] && m_vpn[i] == int'(fill_vpn) && m_asid[i] == int'(fill_asid)) slot = i;
        if (slot < 0)
          for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
        if (slot < 0) begin
          slot = m_rr;
          m_rr = (m_rr + 1) % N;
        end
        m_v[slot] = 1; m_vpn[slot] = int'(fill_vpn); m_asid[slot] = int'(fill_asid);
        m_frm[slot] = int'(fill_frame); m_wr[slot] = fill_writable;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R5", int'(lk_ready), int'(!e_valid || rsp_ready), "lk_ready");
      chk("R12", int'(fill_ready), int'(!(inv_all || inv_asid_en)), "fill_ready");
      chk(cur_tag, int'(rsp_valid), int'(e_valid), "rsp_valid");
      if (e_valid) begin
        chk(cur_tag, int'(rsp_hit), int'(e_hit), "rsp_hit");
        chk(cur_tag, int'(rsp_fault), int'(e_fault), "rsp_fault");
        chk(cur_tag, int'(rsp_frame), e_frame, "rsp_frame");
      end
    end
  end

  task automatic idle_inputs();
    lk_valid = 0; fill_valid = 0; inv_all = 0; inv_asid_en = 0;
  endtask

  task automatic look(input int vpn, input int asid, input bit wr);
    @(negedge clk);
    idle_inputs();
    lk_valid = 1; lk_vpn = 22'(vpn); lk_asid = 8'(asid); lk_write = wr;
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic fill(input int vpn, input int asid, input int frm, input bit wr);
    @(negedge clk);
    idle_inputs();
    fill_valid = 1; fill_vpn = 22'(vpn); fill_asid = 8'(asid);
    fill_frame = 22'(frm); fill_writable = wr;
    @(negedge clk);
    fill_valid = 0;
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 20000) begin @(posedge clk); cyc++; end
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_tag = "R1";
    chk("R1", int'(rsp_valid), 0, "rsp_valid after reset");
    chk("R1", int'(lk_ready), 1, "lk_ready after reset");
    chk("R1", int'(fill_ready), 1, "fill_ready after reset");
    look(5, 1, 0);  // R1: empty table misses

    cur_tag = "R2";
    fill(100, 1, 7000, 1);
    fill(101, 1, 7001, 1);
    fill(100, 2, 7002, 1);
    look(100, 1, 0); look(101, 1, 1); look(100, 2, 0);

    cur_tag = "R3";
    look(100, 3, 0); look(102, 1, 0); look(101, 2, 1);

    cur_tag = "R4";
    fill(200, 1, 9000, 0);
    look(200, 1, 1); look(200, 1, 0);

    cur_tag = "R7";
    fill(100, 1, 7777, 0);
    look(100, 1, 0); look(100, 1, 1);

    cur_tag = "R8";
    for (int k = 0; k < 12; k++) fill(300 + k, 4, 8000 + k, 1);
    look(311, 4, 0);

    cur_tag = "R9";
    for (int k = 0; k < 20; k++) fill(500 + k, 5, 6000 + k, k[0]);
    for (int k = 0; k < 20; k++) look(500 + k, 5, 0);
    look(100, 1, 0); look(300, 4, 0);

    cur_tag = "R5";
    @(negedge clk);
    idle_inputs();
    rsp_ready = 0; lk_valid = 1; lk_vpn = 22'(519); lk_asid = 8'(5); lk_write = 0;
    repeat (3) @(negedge clk);
    lk_vpn = 22'(518);
    repeat (2) @(negedge clk);
    rsp_ready = 1;
    @(negedge clk);
    lk_valid = 0;
    @(negedge clk);

    cur_tag = "R6";
    @(negedge clk);
    lk_valid = 1; lk_vpn = 22'(900); lk_asid = 8'(9); lk_write = 0;
    fill_valid = 1; fill_vpn = 22'(900); fill_asid = 8'(9); fill_frame = 22'(1234); fill_writable = 1;
    @(negedge clk);
    idle_inputs();
    look(900, 9, 0);
    @(negedge clk);
    lk_valid = 1; lk_vpn = 22'(900); lk_asid = 8'(9);
    inv_asid_en = 1; inv_asid = 8'(9);
    @(negedge clk);
    idle_inputs();
    look(900, 9, 0);

    cur_tag = "R11";
    fill(40, 6, 4000, 1);
    fill(41, 7, 4100, 1);
    fill(42, 6, 4200, 1);
    @(negedge clk);
    idle_inputs(); inv_asid_en = 1; inv_asid = 8'(6);
    @(negedge clk);
    idle_inputs();
    look(40, 6, 0); look(42, 6, 0); look(41, 7, 0);

    cur_tag = "R12";
    @(negedge clk);
    inv_asid_en = 1; inv_asid = 8'(77);
    fill_valid = 1; fill_vpn = 22'(60); fill_asid = 8'(3); fill_frame = 22'(600); fill_writable = 1;
    @(negedge clk);
    idle_inputs();
    look(60, 3, 0);

    cur_tag = "R10";
    @(negedge clk);
    idle_inputs(); inv_all = 1;
    @(negedge clk);
    idle_inputs();
    look(41, 7, 0); look(519, 5, 0);
    fill(61, 3, 610, 1);
    look(61, 3, 0);
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule